// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit processor status word and applies the flag operations that do not come out of the arithmetic unit. The instruction sequencer presents an encoded operation on `op_i` and raises `wr_i` for one clock. On that rising edge the block performs the operation:

- it sets or clears one of the three flags that have dedicated operations;
- it loads the word from accumulator A;
- it copies the word out to the accumulator bus;
- it updates the result flags after an accumulator load or clear.

The mask for the non-maskable interrupt can only be cleared by software. The block enforces this in hardware, so no operation can set it again.

The status word is laid out from MSB to LSB as follows:

| Bit | Flag |
|-----|------|
| 7 | S, stop-disable |
| 6 | X, non-maskable interrupt mask |
| 5 | H, half-carry |
| 4 | I, interrupt mask |
| 3 | N, negative |
| 2 | Z, zero |
| 1 | V, overflow |
| 0 | C, carry |

The word and the accumulator copy both come out of registers.

Operation codes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | none |
| 1 | carry clear |
| 2 | interrupt-mask clear |
| 3 | overflow clear |
| 4 | carry set |
| 5 | interrupt-mask set |
| 6 | overflow set |
| 7 | word-from-A |
| 8 | word-to-A |
| 9 | load-flags |
| 10 | clear-flags |
| 11 to 15 | reserved, no effect |

Top module: `ccr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `status_o` becomes 0xD0 (S, X and I at 1, all other flags at 0) and `acc_o` becomes 0x00.
- R2: With `wr_i` high, codes 1 to 6 clear or set only bit 0 (C), bit 4 (I) or bit 1 (V), as the code names. All other bits keep their value, and the result is on `status_o` one cycle later.
- R3: With `wr_i` high, code 7 copies `acc_a_i` into bits 7, 5, 4, 3, 2, 1 and 0 of the word. This includes S and H, whose only direct write path is this operation.
- R4: Code 7 sets bit 6 (X) to `acc_a_i[6]` AND the current X. X can therefore go from 1 to 0 but never from 0 to 1.
- R5: With `wr_i` high, code 8 places the word as it stood before the edge on `acc_o`, one cycle later, and leaves `status_o` unchanged.
- R6: With `wr_i` high, code 9 sets N to `result_i[7]`, sets Z to 1 exactly when `result_i` is 0x00, clears V, and leaves S, X, H, I and C unchanged.
- R7: With `wr_i` high, code 10 clears N, sets Z and clears V whatever `result_i` is, and leaves S, X, H, I and C unchanged.
- R8: `wr_i` low, code 0 or codes 11 to 15 leave both `status_o` and `acc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Encoded flag operation |
| wr_i | input | 1 | Operation strobe |
| acc_a_i | input | 8 | Accumulator A, source for word-from-A |
| result_i | input | 8 | Value loaded into an accumulator, source for load-flags |
| status_o | output | 8 | Registered status word |
| acc_o | output | 8 | Registered copy of the word from the last word-to-A |

## Verification
Every result is due exactly one rising edge after the strobe: `status_o` for the flag operations and `acc_o` for word-to-A. The bench drives each stimulus on a falling edge. It compares both outputs against its reference model at the next falling edge, which is half a period after the single register stage has updated. Directed steps cover the one-way X rule in both directions, and the load flags for 0x80 and 0x00. Random operations, including reserved codes and cycles with the strobe low, follow the directed steps.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned OP_W   = 4;

  localparam int unsigned B_S = 7;
  localparam int unsigned B_X = 6;
  localparam int unsigned B_H = 5;
  localparam int unsigned B_I = 4;
  localparam int unsigned B_N = 3;
  localparam int unsigned B_Z = 2;
  localparam int unsigned B_V = 1;
  localparam int unsigned B_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 4'd0,
    OP_C_CLR   = 4'd1,
    OP_I_CLR   = 4'd2,
    OP_V_CLR   = 4'd3,
    OP_C_SET   = 4'd4,
    OP_I_SET   = 4'd5,
    OP_V_SET   = 4'd6,
    OP_FROM_A  = 4'd7,
    OP_TO_A    = 4'd8,
    OP_LOADF   = 4'd9,
    OP_CLEARF  = 4'd10
  } ccr_op_e;

  typedef struct packed {
    logic c_clr;
    logic i_clr;
    logic v_clr;
    logic c_set;
    logic i_set;
    logic v_set;
    logic from_a;
    logic to_a;
    logic loadf;
    logic clearf;
  } ccr_ctl_t;
endpackage

// File: rtl/ccr_op_decode.sv
module ccr_op_decode
  import ccr_pkg::*;
(
  input  logic            wr_i,
  input  logic [OP_W-1:0] op_i,
  output ccr_ctl_t        ctl_o
);
  always_comb begin
    ctl_o = '0;
    if (wr_i) begin
      case (op_i)
        OP_C_CLR:  ctl_o.c_clr  = 1'b1;
        OP_I_CLR:  ctl_o.i_clr  = 1'b1;
        OP_V_CLR:  ctl_o.v_clr  = 1'b1;
        OP_C_SET:  ctl_o.c_set  = 1'b1;
        OP_I_SET:  ctl_o.i_set  = 1'b1;
        OP_V_SET:  ctl_o.v_set  = 1'b1;
        OP_FROM_A: ctl_o.from_a = 1'b1;
        OP_TO_A:   ctl_o.to_a   = 1'b1;
        OP_LOADF:  ctl_o.loadf  = 1'b1;
        OP_CLEARF: ctl_o.clearf = 1'b1;
        default:   ctl_o = '0;
      endcase
    end
  end

  // Decoder never raises two controls at once (R8: reserved codes do nothing)
  always_comb begin
    assert ($onehot0(ctl_o)) else $error("p_single_ctl_r8 violated");
  end
endmodule

// File: rtl/ccr_next_state.sv
module ccr_next_state
  import ccr_pkg::*;
(
  input  ccr_ctl_t          ctl_i,
  input  logic [FLAG_W-1:0] cur_i,
  input  logic [FLAG_W-1:0] acc_a_i,
  input  logic [FLAG_W-1:0] result_i,
  output logic [FLAG_W-1:0] nxt_o,
  output logic              upd_o
);
  logic [FLAG_W-1:0] tap_word;
  logic              res_zero;

  assign res_zero = (result_i == '0);

  // X may only fall: the incoming bit is gated by the present value.
  always_comb begin
    tap_word      = acc_a_i;
    tap_word[B_X] = acc_a_i[B_X] & cur_i[B_X];
  end

  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b1;
    unique case (1'b1)
      ctl_i.c_clr:  nxt_o[B_C] = 1'b0;
      ctl_i.i_clr:  nxt_o[B_I] = 1'b0;
      ctl_i.v_clr:  nxt_o[B_V] = 1'b0;
      ctl_i.c_set:  nxt_o[B_C] = 1'b1;
      ctl_i.i_set:  nxt_o[B_I] = 1'b1;
      ctl_i.v_set:  nxt_o[B_V] = 1'b1;
      ctl_i.from_a: nxt_o      = tap_word;
      ctl_i.loadf: begin
        nxt_o[B_N] = result_i[FLAG_W-1];
        nxt_o[B_Z] = res_zero;
        nxt_o[B_V] = 1'b0;
      end
      ctl_i.clearf: begin
        nxt_o[B_N] = 1'b0;
        nxt_o[B_Z] = 1'b1;
        nxt_o[B_V] = 1'b0;
      end
      default: upd_o = 1'b0;
    endcase
  end

  // X never rises in the computed word (R4)
  always_comb begin
    assert (!(nxt_o[B_X] && !cur_i[B_X])) else $error("p_x_oneway_comb_r4 violated");
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter logic [7:0] RESET_WORD = 8'hD0
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] op_i,
  input  logic       wr_i,
  input  logic [7:0] acc_a_i,
  input  logic [7:0] result_i,
  output logic [7:0] status_o,
  output logic [7:0] acc_o
);
  ccr_ctl_t          ctl;
  logic [FLAG_W-1:0] status_q;
  logic [FLAG_W-1:0] acc_q;
  logic [FLAG_W-1:0] nxt;
  logic              upd;

  ccr_op_decode u_dec (
    .wr_i  (wr_i),
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  ccr_next_state u_nxt (
    .ctl_i    (ctl),
    .cur_i    (status_q),
    .acc_a_i  (acc_a_i),
    .result_i (result_i),
    .nxt_o    (nxt),
    .upd_o    (upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= RESET_WORD;
      acc_q    <= '0;
    end else begin
      if (upd)       status_q <= nxt;
      if (ctl.to_a)  acc_q    <= status_q;
    end
  end

  assign status_o = status_q;
  assign acc_o    = acc_q;

  // R4: once X is clear it stays clear
  p_x_stays_low_r4: assert property (@(posedge clk) disable iff (rst)
    !status_q[B_X] |=> !status_q[B_X]);

  // R8: no strobe means no change on either output
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ($stable(status_q) && $stable(acc_q)));

  // R5: word-to-A copies the old word and leaves the word alone
  p_to_a_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && op_i == OP_TO_A) |=> (acc_q == $past(status_q) && $stable(status_q)));

  // R7: clear-flags gives N=0, Z=1, V=0
  p_clear_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_i && op_i == OP_CLEARF) |=> (status_q[B_N:B_V] == 3'b010));

  // R3: H only moves on word-from-A
  p_h_only_tap_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && op_i == OP_FROM_A) |=> $stable(status_q[B_H]));

  // R6: load-flags tracks the result sign and zero
  p_load_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && op_i == OP_LOADF) |=>
      (status_q[B_N] == $past(result_i[7]) && status_q[B_Z] == ($past(result_i) == 8'h00)
       && !status_q[B_V]));
endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op_i;
  logic       wr_i;
  logic [7:0] acc_a_i;
  logic [7:0] result_i;
  logic [7:0] status_o;
  logic [7:0] acc_o;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  logic [7:0]  m_stat;
  logic [7:0]  m_acc;

  always #2.5 clk = ~clk;

  ccr_unit u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .wr_i(wr_i),
    .acc_a_i(acc_a_i), .result_i(result_i),
    .status_o(status_o), .acc_o(acc_o)
  );

  // Reference: bit order S X H I N Z V C
  function automatic logic [7:0] ref_stat(logic [7:0] s, logic w, logic [3:0] op,
                                          logic [7:0] a, logic [7:0] r);
    logic [7:0] n = s;
    if (!w) return s;
    case (op)
      4'd1: n[0] = 1'b0;
      4'd2: n[4] = 1'b0;
      4'd3: n[1] = 1'b0;
      4'd4: n[0] = 1'b1;
      4'd5: n[4] = 1'b1;
      4'd6: n[1] = 1'b1;
      4'd7: begin n = a; n[6] = a[6] && s[6]; end
      4'd9: begin n[3] = r[7]; n[2] = (r == 8'd0); n[1] = 1'b0; end
      4'd10: begin n[3] = 1'b0; n[2] = 1'b1; n[1] = 1'b0; end
      default: n = s;
    endcase
    return n;
  endfunction

  function automatic string tag_of(logic w, logic [3:0] op);
    if (!w) return "R8";
    case (op)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return "R2";
      4'd7: return "R3/R4";
      4'd8: return "R5";
      4'd9: return "R6";
      4'd10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(string tag);
    n_vec++;
    if (status_o !== m_stat || acc_o !== m_acc) begin
      n_fail++;
      $display("FAIL %s: status=%h acc=%h expected status=%h acc=%h",
               tag, status_o, acc_o, m_stat, m_acc);
    end
  endtask

  // Drive on a falling edge, check at the next falling edge
  task automatic step(logic w, logic [3:0] op, logic [7:0] a, logic [7:0] r);
    logic [7:0] prev;
    wr_i = w; op_i = op; acc_a_i = a; result_i = r;
    prev   = m_stat;
    m_stat = ref_stat(m_stat, w, op, a, r);
    if (w && op == 4'd8) m_acc = prev;
    @(negedge clk);
    compare(tag_of(w, op));
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_i = 1'b0; op_i = 4'd0; acc_a_i = 8'h00; result_i = 8'h00;
    m_stat = 8'hD0; m_acc = 8'h00;
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(1'b0, 4'd4, 8'h00, 8'h00);   // R8 strobe low
    step(1'b1, 4'd4, 8'h00, 8'h00);   // R2 carry set
    step(1'b1, 4'd6, 8'h00, 8'h00);   // R2 overflow set
    step(1'b1, 4'd2, 8'h00, 8'h00);   // R2 I clear
    step(1'b1, 4'd1, 8'h00, 8'h00);   // R2 carry clear
    step(1'b1, 4'd8, 8'h00, 8'h00);   // R5 copy out
    step(1'b1, 4'd9, 8'h00, 8'h80);   // R6 N=1 Z=0
    step(1'b1, 4'd9, 8'h00, 8'h00);   // R6 Z=1
    step(1'b1, 4'd10, 8'h00, 8'h7F);  // R7
    step(1'b1, 4'd7, 8'hFF, 8'h00);   // R3 all ones, X kept 1
    step(1'b1, 4'd7, 8'h00, 8'h00);   // R4 X falls
    step(1'b1, 4'd7, 8'hFF, 8'h00);   // R4 X stays 0 -> BF
    if (status_o !== 8'hBF) begin
      n_fail++;
      $display("FAIL R4: status=%h expected %h", status_o, 8'hBF);
    end
    n_vec++;
    step(1'b1, 4'd12, 8'h00, 8'h00);  // R8 reserved code
    step(1'b1, 4'd0, 8'h00, 8'h00);   // R8 none
    // re-enter reset: R1
    rst = 1'b1; m_stat = 8'hD0; m_acc = 8'h00;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic       w  = ($urandom % 8) != 0;
      logic [3:0] op = 4'($urandom % 16);
      step(w, op, 8'($urandom), 8'($urandom % 4 == 0 ? 0 : $urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule